// File: doc/BRIEF.md
# Per-Process Page Translation Matrix

This block translates the linear addresses of a small CPU into physical addresses. Every process owns one translation table, and all tables together form a matrix held in dedicated on-chip storage outside main memory. Table 0 belongs to the kernel, and the kernel runs with translation active just as user code does. For each bus request the block forms a super-linear address as process number × 2^LIN_W + linear address. That is the process number placed above the linear address, so each table sits 2^VPN_W entries after the one before it. The upper bits of this address, `{process, virtual page}`, select a matrix entry. The entry gives the physical frame, a valid flag and a supervisor flag. The page offset passes straight through.

During interrupt service the block translates through table 0, whatever the current process is. Kernel code can therefore reach a user buffer with paging left on, by using a super-linear address built from the caller's process number. Supervisor code reads and writes matrix entries through a data port. It can address an entry directly by its index, or through a pointer register that is loaded beforehand and then used like a pseudo-register. Paging can be switched off, in which case addresses pass through untranslated.

The full-size configuration is `PROC_W=5, VPN_W=12, OFF_W=12`. It gives a 29-bit super-linear address, a 17-bit entry index and a 24-bit physical address. The default parameters are smaller so that the storage stays compact.

Top module: `pmx_translate`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mem_start`, `fault`, `mx_rvalid` and `mx_deny` are low. Reset marks every matrix entry invalid, so a later paged lookup faults and a read returns an all-zero word.
- R2: With `pg_en` high, a request on `req_valid` selects the entry `{cur_proc, lin_addr[LIN_W-1:OFF_W]}`. One clock later `phys_addr` is `{frame, offset}`, and `mem_start` is high for one cycle if the entry is valid.
- R3: The low `OFF_W` bits of `phys_addr` equal the low `OFF_W` bits of the requesting `lin_addr`.
- R4: When `in_irq` is high at a request, the lookup uses table 0, with entry index `{0, virtual page}`, and ignores `cur_proc`.
- R5: A paged lookup that hits an invalid entry raises `fault` for one cycle and keeps `mem_start` low. A cycle with no request raises neither of them in the next cycle.
- R6: With paging on, `page_sup` reports the entry's supervisor bit. With paging off, it reads 1.
- R7: An entry word is 14 bits: bit 13 is valid, bit 12 is supervisor, and bits 11:0 are the frame. A permitted read (`mx_req=1`, `mx_wr=0`) returns the selected entry on `mx_rdata` one clock later, with `mx_rvalid` high.
- R8: With `pg_en` low, `phys_addr` is `lin_addr` zero-extended. `mem_start` is high and no fault is raised.
- R9: A matrix write, read or pointer load made while `mx_priv` is low has no effect on the matrix, on `mx_rdata` validity or on the pointer. `mx_deny` is high one clock later.
- R10: `mx_ptr_ld` loads the pointer from `mx_idx`. When `mx_mode` is 1, accesses use the pointer and ignore `mx_idx`. When `mx_mode` is 0, accesses use `mx_idx`.
- R11: A permitted write is visible to the next translation. A translation in the same cycle as a write to the same entry uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_en | input | 1 | Paging enable |
| in_irq | input | 1 | Interrupt service in progress; forces table 0 |
| cur_proc | input | PROC_W | Current process number |
| req_valid | input | 1 | Translation request |
| lin_addr | input | VPN_W+OFF_W | Linear address |
| mem_start | output | 1 | Memory cycle may start (registered) |
| phys_addr | output | FRAME_W+OFF_W | Physical address (registered) |
| page_sup | output | 1 | Supervisor flag of the translated page |
| fault | output | 1 | Lookup hit an invalid entry |
| mx_priv | input | 1 | Issuer is executing from a supervisor page |
| mx_req | input | 1 | Matrix data-port access |
| mx_wr | input | 1 | 1 = write, 0 = read |
| mx_mode | input | 1 | 0 = index from mx_idx, 1 = pointer register |
| mx_ptr_ld | input | 1 | Load pointer register from mx_idx |
| mx_idx | input | PROC_W+VPN_W | Entry index (upper bits of a super-linear address) |
| mx_wdata | input | 14 | Entry word to write |
| mx_rdata | output | 14 | Entry word read |
| mx_rvalid | output | 1 | mx_rdata updated this cycle |
| mx_deny | output | 1 | Previous access refused for lack of privilege |

## Verification
A supervisor write to the matrix and a bus translation can land on the same entry in the same clock. The bench provokes this by driving a data-port write and a request whose process and page select that entry in one cycle. It passes only if the translation returns the frame, valid flag and supervisor flag just written, not the stored ones. A second request to that entry in the following cycle must agree. Unprivileged accesses interleaved with privileged ones are judged by reading the affected entries back afterwards.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int FRAME_W = 12;

    typedef struct packed {
        logic               valid;
        logic               sup;
        logic [FRAME_W-1:0] frame;
    } pmx_entry_t;

    localparam int ENTRY_BITS = $bits(pmx_entry_t);

    typedef enum logic {
        ACC_DIRECT  = 1'b0,
        ACC_POINTER = 1'b1
    } pmx_acc_e;

    function automatic logic entry_usable(input pmx_entry_t e);
        return e.valid;
    endfunction

endpackage

// File: rtl/pmx_index.sv
module pmx_index #(
    parameter  int PROC_W = 2,
    parameter  int VPN_W  = 6,
    localparam int IDX_W  = PROC_W + VPN_W
) (
    input  logic              in_irq,
    input  logic [PROC_W-1:0] cur_proc,
    input  logic [VPN_W-1:0]  vpn,
    output logic [IDX_W-1:0]  xl_idx
);

    // Interrupt service always walks the kernel's table.
    logic [PROC_W-1:0] eff_proc;

    assign eff_proc = in_irq ? '0 : cur_proc;
    assign xl_idx   = {eff_proc, vpn};

endmodule

// File: rtl/pmx_store.sv
module pmx_store
    import pmx_pkg::*;
#(
    parameter  int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pmx_entry_t       wr_data,
    input  logic [IDX_W-1:0] xl_idx,
    output pmx_entry_t       xl_data,
    input  logic [IDX_W-1:0] port_idx,
    output pmx_entry_t       port_data
);

    pmx_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // A write in flight is forwarded to readers of the same entry.
    always_comb begin
        if (wr_en && (wr_idx == xl_idx)) begin
            xl_data = wr_data;
        end else begin
            xl_data = mem[xl_idx];
        end
    end

    always_comb begin
        if (wr_en && (wr_idx == port_idx)) begin
            port_data = wr_data;
        end else begin
            port_data = mem[port_idx];
        end
    end

endmodule

// File: rtl/pmx_port.sv
module pmx_port
    import pmx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mx_priv,
    input  logic             mx_req,
    input  logic             mx_wr,
    input  pmx_acc_e         mx_mode,
    input  logic             mx_ptr_ld,
    input  logic [IDX_W-1:0] mx_idx,
    input  pmx_entry_t       mx_wdata,
    input  pmx_entry_t       port_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] acc_idx,
    output pmx_entry_t       wr_data,
    output pmx_entry_t       mx_rdata,
    output logic             mx_rvalid,
    output logic             mx_deny
);

    logic [IDX_W-1:0] ptr_q;
    logic             rd_ok;

    assign acc_idx = (mx_mode == ACC_POINTER) ? ptr_q : mx_idx;
    assign wr_en   = mx_req & mx_wr & mx_priv;
    assign rd_ok   = mx_req & ~mx_wr & mx_priv;
    assign wr_data = mx_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            mx_rdata  <= '0;
            mx_rvalid <= 1'b0;
            mx_deny   <= 1'b0;
        end else begin
            if (mx_ptr_ld && mx_priv) begin
                ptr_q <= mx_idx;
            end
            if (rd_ok) begin
                mx_rdata <= port_data;
            end
            mx_rvalid <= rd_ok;
            mx_deny   <= (mx_req | mx_ptr_ld) & ~mx_priv;
        end
    end

endmodule

// File: rtl/pmx_xlate.sv
module pmx_xlate
    import pmx_pkg::*;
#(
    parameter  int LIN_W  = 18,
    parameter  int OFF_W  = 12,
    localparam int PHYS_W = FRAME_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              pg_en,
    input  logic [LIN_W-1:0]  lin_addr,
    input  pmx_entry_t        hit,
    output logic              mem_start,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              page_sup,
    output logic              fault
);

    logic [PHYS_W-1:0] phys_n;
    logic              sup_n;
    logic              fault_n;

    always_comb begin
        if (pg_en) begin
            phys_n  = {hit.frame, lin_addr[OFF_W-1:0]};
            sup_n   = hit.sup;
            fault_n = ~entry_usable(hit);
        end else begin
            phys_n  = PHYS_W'(lin_addr);
            sup_n   = 1'b1;
            fault_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_start <= 1'b0;
            fault     <= 1'b0;
            phys_addr <= '0;
            page_sup  <= 1'b0;
        end else begin
            mem_start <= req_valid & ~fault_n;
            fault     <= req_valid & fault_n;
            if (req_valid) begin
                phys_addr <= phys_n;
                page_sup  <= sup_n;
            end
        end
    end

endmodule

// File: rtl/pmx_translate.sv
module pmx_translate
    import pmx_pkg::*;
#(
    parameter  int PROC_W = 2,
    parameter  int VPN_W  = 6,
    parameter  int OFF_W  = 12,
    localparam int LIN_W  = VPN_W + OFF_W,
    localparam int IDX_W  = PROC_W + VPN_W,
    localparam int PHYS_W = FRAME_W + OFF_W,
    localparam int ENT_W  = ENTRY_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_en,
    input  logic              in_irq,
    input  logic [PROC_W-1:0] cur_proc,
    input  logic              req_valid,
    input  logic [LIN_W-1:0]  lin_addr,
    output logic              mem_start,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              page_sup,
    output logic              fault,
    input  logic              mx_priv,
    input  logic              mx_req,
    input  logic              mx_wr,
    input  logic              mx_mode,
    input  logic              mx_ptr_ld,
    input  logic [IDX_W-1:0]  mx_idx,
    input  logic [ENT_W-1:0]  mx_wdata,
    output logic [ENT_W-1:0]  mx_rdata,
    output logic              mx_rvalid,
    output logic              mx_deny
);

    logic [IDX_W-1:0] xl_idx;
    logic [IDX_W-1:0] acc_idx;
    logic             wr_en;
    pmx_entry_t       wr_data;
    pmx_entry_t       xl_data;
    pmx_entry_t       port_data;
    pmx_entry_t       rdata_s;

    pmx_index #(.PROC_W(PROC_W), .VPN_W(VPN_W)) u_index (
        .in_irq   (in_irq),
        .cur_proc (cur_proc),
        .vpn      (lin_addr[LIN_W-1:OFF_W]),
        .xl_idx   (xl_idx)
    );

    pmx_port #(.IDX_W(IDX_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .mx_priv   (mx_priv),
        .mx_req    (mx_req),
        .mx_wr     (mx_wr),
        .mx_mode   (pmx_acc_e'(mx_mode)),
        .mx_ptr_ld (mx_ptr_ld),
        .mx_idx    (mx_idx),
        .mx_wdata  (pmx_entry_t'(mx_wdata)),
        .port_data (port_data),
        .wr_en     (wr_en),
        .acc_idx   (acc_idx),
        .wr_data   (wr_data),
        .mx_rdata  (rdata_s),
        .mx_rvalid (mx_rvalid),
        .mx_deny   (mx_deny)
    );

    assign mx_rdata = rdata_s;

    pmx_store #(.IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (acc_idx),
        .wr_data   (wr_data),
        .xl_idx    (xl_idx),
        .xl_data   (xl_data),
        .port_idx  (acc_idx),
        .port_data (port_data)
    );

    pmx_xlate #(.LIN_W(LIN_W), .OFF_W(OFF_W)) u_xlate (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .pg_en     (pg_en),
        .lin_addr  (lin_addr),
        .hit       (xl_data),
        .mem_start (mem_start),
        .phys_addr (phys_addr),
        .page_sup  (page_sup),
        .fault     (fault)
    );

endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
    parameter  int PROC_W = 2,
    parameter  int VPN_W  = 6,
    parameter  int OFF_W  = 12,
    localparam int LIN_W  = VPN_W + OFF_W,
    localparam int PHYS_W = 12 + OFF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              pg_en,
    input logic              req_valid,
    input logic [LIN_W-1:0]  lin_addr,
    input logic              mem_start,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              fault,
    input logic              mx_priv,
    input logic              mx_req,
    input logic              mx_wr,
    input logic              mx_rvalid,
    input logic              mx_deny
);

    // R5: a faulting lookup never opens a memory cycle
    a_r5_fault_blocks_cycle: assert property (@(posedge clk) disable iff (rst)
        fault |-> !mem_start);

    // R5: no request, no outcome
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_start && !fault));

    // R3: offset bits pass through a paged lookup
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pg_en) |=> (phys_addr[OFF_W-1:0] == $past(lin_addr[OFF_W-1:0])));

    // R8: paging off gives a flat mapping
    a_r8_flat_map: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pg_en) |=> (mem_start && !fault && phys_addr == PHYS_W'($past(lin_addr))));

    // R9: unprivileged access is refused
    a_r9_deny: assert property (@(posedge clk) disable iff (rst)
        (mx_req && !mx_priv) |=> (mx_deny && !mx_rvalid));

    // R7: a permitted read is acknowledged next cycle
    a_r7_read_ack: assert property (@(posedge clk) disable iff (rst)
        (mx_req && !mx_wr && mx_priv) |=> (mx_rvalid && !mx_deny));

endmodule

bind pmx_translate pmx_checker #(.PROC_W(PROC_W), .VPN_W(VPN_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/pmx_translate_tb.sv
`timescale 1ns/1ps
module pmx_translate_tb;

    localparam int PW = 2;
    localparam int VW = 6;
    localparam int OW = 12;
    localparam int LW = VW + OW;
    localparam int IW = PW + VW;
    localparam int NE = 1 << IW;

    logic          clk = 1'b0;
    logic          rst;
    logic          pg_en, in_irq, req_valid;
    logic [PW-1:0] cur_proc;
    logic [LW-1:0] lin_addr;
    logic          mem_start, page_sup, fault;
    logic [23:0]   phys_addr;
    logic          mx_priv, mx_req, mx_wr, mx_mode, mx_ptr_ld;
    logic [IW-1:0] mx_idx;
    logic [13:0]   mx_wdata, mx_rdata;
    logic          mx_rvalid, mx_deny;

    int n_chk  = 0;
    int n_fail = 0;
    logic [13:0] exp_mem [NE];

    always #2.5 clk = ~clk;

    pmx_translate #(.PROC_W(PW), .VPN_W(VW), .OFF_W(OW)) u_dut (
        .clk(clk), .rst(rst), .pg_en(pg_en), .in_irq(in_irq), .cur_proc(cur_proc),
        .req_valid(req_valid), .lin_addr(lin_addr), .mem_start(mem_start),
        .phys_addr(phys_addr), .page_sup(page_sup), .fault(fault),
        .mx_priv(mx_priv), .mx_req(mx_req), .mx_wr(mx_wr), .mx_mode(mx_mode),
        .mx_ptr_ld(mx_ptr_ld), .mx_idx(mx_idx), .mx_wdata(mx_wdata),
        .mx_rdata(mx_rdata), .mx_rvalid(mx_rvalid), .mx_deny(mx_deny)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] pat(input int idx, input int salt);
        logic [11:0] fr;
        logic v, s;
        fr = 12'((idx * 37 + salt * 101 + 5) & 32'hFFF);
        v  = ((idx + salt) % 7) != 3;
        s  = ((idx >> 2) & 1) == 1;
        return {v, s, fr};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_port();
        mx_req = 0; mx_wr = 0; mx_mode = 0; mx_ptr_ld = 0; mx_priv = 0;
        mx_idx = '0; mx_wdata = '0;
    endtask

    task automatic mx_write(input int idx, input logic [13:0] d, input bit priv, input bit mode);
        mx_req = 1; mx_wr = 1; mx_idx = IW'(idx); mx_wdata = d; mx_priv = priv; mx_mode = mode;
        step();
        clear_port();
    endtask

    task automatic mx_read(input int idx, input bit priv, input bit mode,
                           output logic [13:0] d, output logic rv, output logic dn);
        mx_req = 1; mx_wr = 0; mx_idx = IW'(idx); mx_priv = priv; mx_mode = mode;
        step();
        d = mx_rdata; rv = mx_rvalid; dn = mx_deny;
        clear_port();
    endtask

    function automatic logic [63:0] expect_x(input int proc, input int vpn, input int off,
                                             input bit irq, input bit pg);
        logic [13:0] e;
        logic [LW-1:0] lin;
        int idx;
        lin = {VW'(vpn), OW'(off)};
        idx = irq ? vpn : proc * (1 << VW) + vpn;
        e   = exp_mem[idx];
        if (!pg) return {36'd0, 1'b1, 1'b0, 1'b1, 24'(lin)};
        if (!e[13]) return {36'd0, 1'b0, 1'b1, 25'd0};
        return {36'd0, 1'b1, 1'b0, e[12], e[11:0], 12'(off)};
    endfunction

    task automatic xlate(input int proc, input int vpn, input int off,
                         input bit irq, input bit pg, input string req);
        cur_proc = PW'(proc); in_irq = irq; pg_en = pg;
        lin_addr = {VW'(vpn), OW'(off)}; req_valid = 1;
        step();
        req_valid = 0; in_irq = 0;
        check(req, $sformatf("xlate p%0d v%0d irq%0d pg%0d", proc, vpn, irq, pg),
              {36'd0, mem_start, fault, fault ? 25'd0 : {page_sup, phys_addr}},
              expect_x(proc, vpn, off, irq, pg));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [13:0] d;
        logic rv, dn;
        rst = 1; pg_en = 1; in_irq = 0; req_valid = 0; cur_proc = '0; lin_addr = '0;
        clear_port();
        for (int i = 0; i < NE; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "outputs in reset", {mem_start, fault, mx_rvalid, mx_deny}, 0);
        rst = 0;
        step();
        check("R1", "outputs after reset", {mem_start, fault, mx_rvalid, mx_deny}, 0);

        // R1: matrix starts invalid
        xlate(1, 5, 12'h123, 0, 1, "R1");
        xlate(3, 63, 0, 0, 1, "R1");
        mx_read(200, 1, 0, d, rv, dn);
        check("R1", "reset entry word", {rv, d}, {1'b1, 14'd0});

        // Fill matrix through direct mode
        for (int i = 0; i < NE; i++) begin
            exp_mem[i] = pat(i, 0);
            mx_write(i, exp_mem[i], 1, 0);
        end
        // R7: read-back sweep
        for (int i = 0; i < NE; i += 3) begin
            mx_read(i, 1, 0, d, rv, dn);
            check("R7", $sformatf("read idx %0d", i), {dn, rv, d}, {1'b0, 1'b1, exp_mem[i]});
        end
        // R2 R3 R5 R6: full paged sweep
        for (int p = 0; p < (1 << PW); p++) begin
            for (int v = 0; v < (1 << VW); v++) begin
                xlate(p, v, (v * 291 + p * 7) & 12'hFFF, 0, 1, "R2");
            end
        end
        // R5: quiet cycle after a request
        step();
        check("R5", "no request no outcome", {mem_start, fault}, 0);
        // R4: interrupt forces table 0
        for (int p = 1; p < (1 << PW); p++) begin
            for (int v = 0; v < (1 << VW); v += 5) begin
                xlate(p, v, 12'hABC, 1, 1, "R4");
            end
        end
        // R8 R6: paging off
        for (int v = 0; v < (1 << VW); v += 7) begin
            xlate(2, v, (v * 13) & 12'hFFF, 0, 0, "R8");
        end

        // R9: unprivileged write, read and pointer load
        mx_write(5, 14'h3FFF, 0, 0);
        check("R9", "deny after write", {mx_deny, mx_rvalid}, 2'b10);
        mx_read(5, 1, 0, d, rv, dn);
        check("R9", "entry unchanged", {rv, d}, {1'b1, exp_mem[5]});
        mx_read(6, 0, 0, d, rv, dn);
        check("R9", "denied read", {dn, rv}, 2'b10);

        // R10: pointer load then pointer-mode write and read
        mx_ptr_ld = 1; mx_idx = IW'(77); mx_priv = 1;
        step();
        clear_port();
        mx_ptr_ld = 1; mx_idx = IW'(9); mx_priv = 0;
        step();
        check("R9", "denied pointer load", {mx_deny}, 1'b1);
        clear_port();
        exp_mem[77] = 14'h2A5C;
        mx_write(3, 14'h2A5C, 1, 1);
        mx_read(77, 1, 0, d, rv, dn);
        check("R10", "pointer write lands at 77", {rv, d}, {1'b1, exp_mem[77]});
        mx_read(3, 1, 0, d, rv, dn);
        check("R10", "mx_idx ignored in pointer mode", {rv, d}, {1'b1, exp_mem[3]});
        mx_read(0, 1, 1, d, rv, dn);
        check("R10", "pointer-mode read", {rv, d}, {1'b1, exp_mem[77]});
        mx_read(9, 1, 0, d, rv, dn);
        check("R10", "idx 9 untouched", {rv, d}, {1'b1, exp_mem[9]});

        // R11: same-cycle write and translation of one entry (proc 1, vpn 10 -> idx 74)
        exp_mem[74] = 14'h3123;
        mx_req = 1; mx_wr = 1; mx_idx = IW'(74); mx_wdata = 14'h3123; mx_priv = 1;
        cur_proc = 1; in_irq = 0; pg_en = 1; lin_addr = {VW'(10), 12'h055}; req_valid = 1;
        step();
        req_valid = 0;
        clear_port();
        check("R11", "bypass translation",
              {36'd0, mem_start, fault, page_sup, phys_addr}, expect_x(1, 10, 12'h055, 0, 1));
        xlate(1, 10, 12'h7FF, 0, 1, "R11");
        // R11: invalidate then translate next cycle
        exp_mem[74] = 14'h0000;
        mx_write(74, 14'h0000, 1, 0);
        xlate(1, 10, 12'h001, 0, 1, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule